// File: doc/BRIEF.md
# Zero-Forcing Cursor-Cancelling Transmit Equalizer

This block pre-compensates a serial data stream for the intersymbol interference that a lossy channel adds. Each data bit is mapped to a bipolar symbol and weighted by a programmable main-cursor gain. The block then subtracts the neighbouring symbols' contributions: one pre-cursor term driven by the following symbol and a parameterised number of post-cursor terms driven by earlier symbols. The result is a signed amplitude per symbol. After the channel, symbol-spaced samples of this amplitude are free of the cursors that were cancelled.

The pre-cursor term depends on a symbol that has not yet been sent. For this reason the emitted amplitude always describes the symbol accepted one valid input earlier, and the newest input acts as the look-ahead. The symbol history advances only on cycles with a valid input. The coefficients are treated as static settings. The sum is saturated to the output width.

Top module: `zf_cursor_eq`

## Requirements
- R1: While reset is asserted, and directly after it, `amp_valid_o` is 0 and `amp_o` is 0.
- R2: A data bit of 1 stands for symbol +1 and a bit of 0 stands for symbol −1. For each valid input x[k], the amplitude is C0·x[k−1] − Cpre·x[k] − C1·x[k−2] − C2·x[k−3], where x[k] is the newest accepted symbol. C1 sits in bits [7:0] of `c_post_i` and C2 sits in bits [15:8].
- R3: `amp_o` and `amp_valid_o` update on the clock edge after the one that accepts a valid input. They have no other latency.
- R4: A cycle with `sym_valid_i` low leaves the symbol history and `amp_o` unchanged. `amp_valid_o` is 0 in the following cycle.
- R5: The first two valid inputs after reset produce `amp_valid_o` = 0. The third valid input, and every later one, produces `amp_valid_o` = 1.
- R6: Every history position not yet filled after reset holds symbol −1.
- R7: When the exact sum is outside the signed OUT_W range, `amp_o` is clamped to the nearest limit.
- R8: A coefficient of −128 is weighted exactly, with no wrap on negation.
- R9: The main cursor is added with the sign of its symbol and is never subtracted.
- R10: A reset in the middle of a stream clears the history and restarts the fill count of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_valid_i | input | 1 | A new data bit is present |
| sym_i | input | 1 | Data bit, 1 = +1 and 0 = −1 |
| c_main_i | input | COEF_W | Signed main-cursor gain C0 |
| c_pre_i | input | COEF_W | Signed pre-cursor coefficient |
| c_post_i | input | NPOST*COEF_W | Signed post-cursor coefficients, C1 in the lowest slice |
| amp_o | output | OUT_W | Signed pre-compensated amplitude |
| amp_valid_o | output | 1 | `amp_o` holds a fresh complete amplitude |

## Verification
The bench targets the look-ahead alignment. A design that paired the pre-cursor with the wrong symbol would give sign errors whenever neighbouring bits differ, and those errors show up under pseudo-random patterns. It also targets the fill boundary. A fill counter that is off by one would flag the second output as valid, or would hide the third. The reset history matters too: history that reset to +1 instead of −1 flips the sign of the post-cursor term on the first valid output. Two cases probe the arithmetic. Coefficients of −128 would expose a negation that wraps. A narrow-output instance driven to both extremes would show an output that wraps when it should clamp.

// File: rtl/zf_eq_pkg.sv
package zf_eq_pkg;
  typedef enum logic {
    SYM_NEG = 1'b0,
    SYM_POS = 1'b1
  } sym_e;
endpackage

// File: rtl/zf_sym_line.sv
module zf_sym_line #(
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] q_o
);
  import zf_eq_pkg::*;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic d;
    if (s == 0) begin : g_head
      assign d = bit_i;
    end else begin : g_body
      assign d = q_o[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[s] <= SYM_NEG;
      else if (shift_i) q_o[s] <= d;
    end
  end
endmodule

// File: rtl/zf_tap_term.sv
module zf_tap_term #(
  parameter int COEF_W = 8,
  parameter bit NEGATE = 1'b0
) (
  input  logic                     sym_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [COEF_W:0]   term_o
);
  logic signed [COEF_W:0] ext;

  // one extra bit so that negating the most negative code is exact
  assign ext    = {coef_i[COEF_W-1], coef_i};
  assign term_o = (sym_i ^ NEGATE) ? ext : -ext;
endmodule

// File: rtl/zf_combiner.sv
module zf_combiner #(
  parameter int IN_W  = 9,
  parameter int N     = 4,
  parameter int OUT_W = 12
) (
  input  logic signed [IN_W-1:0]  terms_i [N],
  output logic signed [OUT_W-1:0] sum_o
);
  localparam int SUM_W = IN_W + $clog2(N) + 1;

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + SUM_W'(terms_i[i]);
  end

  if (OUT_W >= SUM_W) begin : g_wide
    assign sum_o = OUT_W'(acc);
  end else begin : g_clamp
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);
    always_comb begin
      if (acc > HI)      sum_o = HI[OUT_W-1:0];
      else if (acc < LO) sum_o = LO[OUT_W-1:0];
      else               sum_o = acc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/zf_cursor_eq.sv
module zf_cursor_eq #(
  parameter int COEF_W = 8,
  parameter int NPOST  = 2,
  parameter int OUT_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sym_valid_i,
  input  logic                    sym_i,
  input  logic [COEF_W-1:0]       c_main_i,
  input  logic [COEF_W-1:0]       c_pre_i,
  input  logic [NPOST*COEF_W-1:0] c_post_i,
  output logic [OUT_W-1:0]        amp_o,
  output logic                    amp_valid_o
);
  localparam int DEPTH  = NPOST + 1;
  localparam int NTERM  = NPOST + 2;
  localparam int TERM_W = COEF_W + 1;
  localparam int FILL   = NPOST + 1;
  localparam int CNT_W  = $clog2(FILL + 1);

  logic [DEPTH-1:0]         hist;
  logic signed [TERM_W-1:0] terms [NTERM];
  logic signed [OUT_W-1:0]  sum;
  logic [CNT_W-1:0]         fill_q;
  logic                     full_next;

  // hist[0] is the symbol now being emitted, sym_i is its look-ahead
  zf_sym_line #(.DEPTH(DEPTH)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sym_valid_i),
    .bit_i   (sym_i),
    .q_o     (hist)
  );

  zf_tap_term #(.COEF_W(COEF_W), .NEGATE(1'b0)) u_main (
    .sym_i  (hist[0]),
    .coef_i (c_main_i),
    .term_o (terms[0])
  );

  zf_tap_term #(.COEF_W(COEF_W), .NEGATE(1'b1)) u_pre (
    .sym_i  (sym_i),
    .coef_i (c_pre_i),
    .term_o (terms[1])
  );

  for (genvar k = 0; k < NPOST; k++) begin : g_post
    zf_tap_term #(.COEF_W(COEF_W), .NEGATE(1'b1)) u_post (
      .sym_i  (hist[k+1]),
      .coef_i (c_post_i[k*COEF_W +: COEF_W]),
      .term_o (terms[k+2])
    );
  end

  zf_combiner #(.IN_W(TERM_W), .N(NTERM), .OUT_W(OUT_W)) u_sum (
    .terms_i (terms),
    .sum_o   (sum)
  );

  assign full_next = (fill_q >= CNT_W'(FILL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
    end else if (sym_valid_i && (fill_q != CNT_W'(FILL))) begin
      fill_q <= fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_o       <= '0;
      amp_valid_o <= 1'b0;
    end else begin
      amp_valid_o <= sym_valid_i && full_next;
      if (sym_valid_i) amp_o <= sum;
    end
  end
endmodule

// File: rtl/zf_cursor_eq_chk.sv
module zf_cursor_eq_chk #(
  parameter int OUT_W = 12,
  parameter int NPOST = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_valid_i,
  input logic [OUT_W-1:0] amp_o,
  input logic             amp_valid_o
);
  localparam int FILL = NPOST + 1;

  int seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_q <= 0;
    else if (sym_valid_i && seen_q < FILL) seen_q <= seen_q + 1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (amp_valid_o == 1'b0 && amp_o == '0);
    end
  end

  assert_valid_after_input_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_o |-> $past(sym_valid_i));

  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> ($stable(amp_o) && !amp_valid_o));

  assert_no_early_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_o |-> (seen_q >= FILL));

  assert_full_gives_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && seen_q >= FILL - 1) |=> amp_valid_o);
endmodule

bind zf_cursor_eq zf_cursor_eq_chk #(.OUT_W(OUT_W), .NPOST(NPOST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .amp_o       (amp_o),
  .amp_valid_o (amp_valid_o)
);

// File: tb/tb_zf_cursor_eq.sv
`timescale 1ns/1ps
module tb_zf_cursor_eq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sym_valid_i = 1'b0;
  logic        sym_i = 1'b0;
  logic [7:0]  c_main_i = '0;
  logic [7:0]  c_pre_i = '0;
  logic [15:0] c_post_i = '0;
  logic [11:0] amp_o;
  logic        amp_valid_o;
  logic [7:0]  amp_sat;
  logic        amp_sat_valid;

  int checks = 0;
  int failures = 0;
  string tag = "R2";

  int hist[$];
  int fill;
  int exp_amp;
  int exp_sat;
  int exp_valid;

  always #5 clk_i = ~clk_i;

  zf_cursor_eq dut (
    .clk_i, .rst_ni, .sym_valid_i, .sym_i, .c_main_i, .c_pre_i, .c_post_i,
    .amp_o, .amp_valid_o
  );

  zf_cursor_eq #(.OUT_W(8)) dut_sat (
    .clk_i, .rst_ni, .sym_valid_i, .sym_i, .c_main_i, .c_pre_i, .c_post_i,
    .amp_o(amp_sat), .amp_valid_o(amp_sat_valid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sc(logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic model_reset();
    hist = '{-1, -1, -1, -1};
    fill = 0;
    exp_amp = 0;
    exp_sat = 0;
    exp_valid = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sym_valid_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #2;
    model_reset();
    check("R1 valid", int'(amp_valid_o), 0);
    check("R1 amp", int'($signed(amp_o)), 0);
    rst_ni = 1'b1;
  endtask

  task automatic step(bit v, bit b);
    sym_valid_i = v;
    sym_i = b;
    @(posedge clk_i);
    if (v) begin
      hist.push_front(b ? 1 : -1);
      void'(hist.pop_back());
      exp_amp = sc(c_main_i) * hist[1] - sc(c_pre_i) * hist[0]
              - sc(c_post_i[7:0]) * hist[2] - sc(c_post_i[15:8]) * hist[3];
      exp_sat = exp_amp > 127 ? 127 : (exp_amp < -128 ? -128 : exp_amp);
      if (fill < 3) fill++;
      exp_valid = (fill >= 3);
    end else begin
      exp_valid = 0;
    end
    #2;
    check(v ? tag : "R4 hold", int'($signed(amp_o)), exp_amp);
    check(fill < 3 ? "R5 valid" : "R3 valid", int'(amp_valid_o), exp_valid);
    check("R7 clamp", int'($signed(amp_sat)), exp_sat);
    sym_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();

    // R6: unfilled history is -1, so only the C2 term shows on the third output
    tag = "R6";
    c_main_i = 8'd0; c_pre_i = 8'd0; c_post_i = {8'sd50, 8'sd0};
    step(1, 1); step(1, 1); step(1, 1);
    check("R6 first output", int'($signed(amp_o)), 50);

    // R9: main cursor only
    tag = "R9";
    c_main_i = 8'sd40; c_post_i = '0;
    step(1, 0); step(1, 1); step(1, 1); step(1, 0);
    check("R9 main add", int'($signed(amp_o)), 40);

    // R2/R4: mixed coefficients, pseudo-random bits with idle gaps
    tag = "R2";
    c_main_i = 8'sd60; c_pre_i = -8'sd10; c_post_i = {-8'sd7, 8'sd20};
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], lfsr[0]);
    end

    // R8 and R7: extreme coefficients
    tag = "R8";
    c_main_i = 8'sd127; c_pre_i = 8'h80; c_post_i = {8'h80, 8'h80};
    step(1, 0); step(1, 0); step(1, 0); step(1, 1); step(1, 0);
    check("R8 R7 low extreme", int'($signed(amp_sat)), -128);
    step(1, 1); step(1, 0); step(1, 1); step(1, 1); step(1, 1);
    step(1, 0);
    check("R8 exact", int'($signed(amp_o)), 127 * 1 - 128 * 1 - 128 * (-1) - 128 * (-1) * 0 + 128 * 1);
    check("R7 high extreme", int'($signed(amp_sat)), 127);

    // R10: reset in the middle of a stream
    tag = "R10";
    c_main_i = 8'sd30; c_pre_i = 8'sd5; c_post_i = {8'sd3, 8'sd9};
    step(1, 1); step(1, 0);
    do_reset();
    step(1, 0);
    check("R10 restart", int'(amp_valid_o), 0);
    step(1, 1);
    check("R10 restart", int'(amp_valid_o), 0);
    step(1, 1);
    check("R10 filled", int'(amp_valid_o), 1);
    for (int i = 0; i < 20; i++) step(i % 3 != 0, i[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule